// File: doc/BRIEF.md
# Effective Register-Width Selector with Cached Result

This block works out the integer register width that applies at the current privilege level of a core that can run narrower code than its widest width. It holds three width fields: the machine field (top two bits of the ISA descriptor register) and the supervisor and user fields (in the machine status register). It combines them with the privilege level and keeps the answer in a register. Downstream execution logic reads a stable code and does not repeat the selection on every cycle.

The cached code changes only when something that can change the answer happens: reset, trap entry or return, a write to the ISA descriptor, or a write to the status register. On a trap, the privilege being entered is used in the same edge. A machine width of 32 forces 32 bits everywhere, whatever the lower fields hold. Writes with an encoding the core does not support are dropped field by field.

Top module: `xlen_sel_cache`

## Requirements
- R1: After reset, all three width fields hold the widest supported code (MAX_XL, default 2) and the effective code output equals MAX_XL.
- R2: When the machine field is 1 (32-bit), every recompute yields code 1 at every privilege level.
- R3: With the machine field not 1, a recompute for machine level (privilege code 3) yields the machine field.
- R4: With the machine field not 1, a recompute for user level (privilege code 0) yields the user field, which sits in status bits 33:32.
- R5: With the machine field not 1, a recompute for supervisor (code 1) or hypervisor (code 2) level yields the supervisor field, which sits in status bits 35:34.
- R6: In a cycle with no trap strobe and no register write strobe, the effective code does not change, even if the privilege input changes.
- R7: A trap strobe recomputes using the trap's target privilege at the same clock edge, so the new code is on the output one cycle after the strobe.
- R8: A write strobe to the descriptor (field in bits DATA_W-1:DATA_W-2) or the status register recomputes from the field values after the write, at the same edge.
- R9: A written width encoding of 0, or one above MAX_XL, leaves that field unchanged. Legal fields in the same write still update.
- R10: While the machine field is 1, status register writes leave the supervisor and user fields unchanged.
- R11: The 32-bit flag output is 1 exactly when the effective code output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege level: 0 user, 1 supervisor, 2 hypervisor, 3 machine |
| trap_fire | input | 1 | Trap entry or return takes effect at this edge |
| trap_priv | input | 2 | Privilege level that the trap enters |
| misa_we | input | 1 | Write strobe for the ISA descriptor register |
| misa_wdata | input | DATA_W | Descriptor write data; width field in the top two bits |
| mstatus_we | input | 1 | Write strobe for the machine status register |
| mstatus_wdata | input | DATA_W | Status write data; user field 33:32, supervisor field 35:34 |
| eff_xl | output | 2 | Cached effective width code: 1 = 32, 2 = 64, 3 = 128 |
| xl32_mode | output | 1 | High when the cached width is 32 bits |

## Verification
Every result of this block lands exactly one cycle after the strobe that causes it. The fields and the cache both update at the edge that samples the strobe, so the new code appears on eff_xl after that edge. Between strobes eff_xl must not move. The bench drives strobes just after a falling edge, lets one rising edge pass, and samples at the next falling edge. A behavioural model advanced on each rising edge is compared with both outputs at every falling edge, so a stray change in an idle cycle is caught at once.

// File: rtl/xlsel_pkg.sv
package xlsel_pkg;

    typedef enum logic [1:0] {
        XL_NONE = 2'd0,
        XL_32   = 2'd1,
        XL_64   = 2'd2,
        XL_128  = 2'd3
    } xl_code_e;

    typedef enum logic [1:0] {
        PRV_USER = 2'd0,
        PRV_SUPV = 2'd1,
        PRV_HYPV = 2'd2,
        PRV_MACH = 2'd3
    } priv_e;

    typedef struct packed {
        logic [1:0] mxl;
        logic [1:0] sxl;
        logic [1:0] uxl;
    } xl_fields_t;

    // A width code is usable if it is nonzero and not wider than the core
    function automatic logic code_ok(input logic [1:0] code, input int max_xl);
        return (code != 2'(XL_NONE)) && (int'(code) <= max_xl);
    endfunction

    // Width selection for one privilege level
    function automatic logic [1:0] pick_width(input xl_fields_t f, input priv_e p);
        logic [1:0] res;
        if (f.mxl == 2'(XL_32)) begin
            res = 2'(XL_32);
        end else begin
            unique case (p)
                PRV_MACH: res = f.mxl;
                PRV_USER: res = f.uxl;
                default:  res = f.sxl;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/xl_field_reg.sv
module xl_field_reg
    import xlsel_pkg::*;
#(
    parameter int         MAX_XL   = 2,
    parameter logic [1:0] RST_CODE = 2'(MAX_XL)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    output logic [1:0] cur,
    output logic [1:0] nxt
);

    logic take;

    assign take = wr_en && code_ok(wr_val, MAX_XL);
    assign nxt  = take ? wr_val : cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RST_CODE;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/xl_resolve.sv
module xl_resolve
    import xlsel_pkg::*;
(
    input  xl_fields_t fields,
    input  priv_e      priv,
    output logic [1:0] code
);

    assign code = pick_width(fields, priv);

endmodule

// File: rtl/xl_cache.sv
module xl_cache
    import xlsel_pkg::*;
#(
    parameter logic [1:0] RST_CODE = 2'(XL_64)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       upd,
    input  logic [1:0] nxt,
    output logic [1:0] code,
    output logic       is32
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= RST_CODE;
        end else if (upd) begin
            code <= nxt;
        end
    end

    assign is32 = (code == 2'(XL_32));

endmodule

// File: rtl/xlen_sel_cache.sv
module xlen_sel_cache
    import xlsel_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int MAX_XL  = 2,
    parameter int UXL_LSB = 32,
    parameter int SXL_LSB = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        priv_i,
    input  logic              trap_fire,
    input  logic [1:0]        trap_priv,
    input  logic              misa_we,
    input  logic [DATA_W-1:0] misa_wdata,
    input  logic              mstatus_we,
    input  logic [DATA_W-1:0] mstatus_wdata,
    output logic [1:0]        eff_xl,
    output logic              xl32_mode
);

    localparam int          MXL_LSB   = DATA_W - 2;
    localparam logic [1:0]  MAX_CODE  = 2'(MAX_XL);
    localparam int          N_LOW     = 2;
    localparam logic [DATA_W-1:0] STAT_MASK =
        (DATA_W'(3) << UXL_LSB) | (DATA_W'(3) << SXL_LSB);

    logic [1:0] misa_fld;
    logic [1:0] mxl_q;
    logic [1:0] mxl_nx;
    logic [1:0] uxl_q;
    logic [1:0] sxl_q;
    logic [1:0] low_cur [N_LOW];
    logic [1:0] low_nxt [N_LOW];
    logic       stat_reach;
    logic       recompute;
    priv_e      tgt_priv;
    xl_fields_t fld_next;
    logic [1:0] sel_code;
    logic       misa_unused;
    logic       stat_unused;

    assign misa_fld    = misa_wdata[MXL_LSB +: 2];
    assign misa_unused = ^misa_wdata[MXL_LSB-1:0];
    assign stat_unused = ^(mstatus_wdata & ~STAT_MASK);

    // Machine width field
    xl_field_reg #(.MAX_XL(MAX_XL), .RST_CODE(MAX_CODE)) u_mxl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (misa_we),
        .wr_val (misa_fld),
        .cur    (mxl_q),
        .nxt    (mxl_nx)
    );

    // Lower fields are only reachable while the machine width is not 32
    assign stat_reach = mstatus_we && (mxl_q != 2'(XL_32));

    for (genvar gi = 0; gi < N_LOW; gi++) begin : g_low
        localparam int LSB = (gi == 0) ? UXL_LSB : SXL_LSB;
        xl_field_reg #(.MAX_XL(MAX_XL), .RST_CODE(MAX_CODE)) u_fld (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (stat_reach),
            .wr_val (mstatus_wdata[LSB +: 2]),
            .cur    (low_cur[gi]),
            .nxt    (low_nxt[gi])
        );
    end

    assign uxl_q = low_cur[0];
    assign sxl_q = low_cur[1];

    assign recompute = trap_fire | misa_we | mstatus_we;
    assign tgt_priv  = trap_fire ? priv_e'(trap_priv) : priv_e'(priv_i);

    assign fld_next.mxl = mxl_nx;
    assign fld_next.uxl = low_nxt[0];
    assign fld_next.sxl = low_nxt[1];

    xl_resolve u_res (
        .fields (fld_next),
        .priv   (tgt_priv),
        .code   (sel_code)
    );

    xl_cache #(.RST_CODE(MAX_CODE)) u_cache (
        .clk  (clk),
        .rst  (rst),
        .upd  (recompute),
        .nxt  (sel_code),
        .code (eff_xl),
        .is32 (xl32_mode)
    );

endmodule

// File: rtl/xlen_sel_cache_chk.sv
module xlen_sel_cache_chk #(
    parameter int MAX_XL = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       trap_fire,
    input logic [1:0] trap_priv,
    input logic       misa_we,
    input logic [1:0] misa_fld,
    input logic       mstatus_we,
    input logic [1:0] mxl_q,
    input logic [1:0] sxl_q,
    input logic [1:0] uxl_q,
    input logic [1:0] eff_xl
);

    AST_RESET_WIDEST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int'(eff_xl) == MAX_XL)); // R1

    AST_LOCK_32: assert property (@(posedge clk) disable iff (rst)
        ((trap_fire || mstatus_we) && !misa_we && mxl_q == 2'd1) |=> (eff_xl == 2'd1)); // R2

    AST_MACH_USES_MXL: assert property (@(posedge clk) disable iff (rst)
        (trap_fire && trap_priv == 2'd3 && !misa_we && mxl_q != 2'd1)
        |=> (eff_xl == $past(mxl_q))); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(trap_fire || misa_we || mstatus_we) |=> $stable(eff_xl)); // R6

    AST_BAD_CODE_DROP: assert property (@(posedge clk) disable iff (rst)
        (misa_we && (misa_fld == 2'd0 || int'(misa_fld) > MAX_XL)) |=> $stable(mxl_q)); // R9

    AST_LOW_UNREACH: assert property (@(posedge clk) disable iff (rst)
        (mstatus_we && mxl_q == 2'd1) |=> ($stable(sxl_q) && $stable(uxl_q))); // R10

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (eff_xl != 2'd0) && (int'(eff_xl) <= MAX_XL)); // R9

endmodule

bind xlen_sel_cache xlen_sel_cache_chk #(.MAX_XL(MAX_XL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trap_fire  (trap_fire),
    .trap_priv  (trap_priv),
    .misa_we    (misa_we),
    .misa_fld   (misa_fld),
    .mstatus_we (mstatus_we),
    .mxl_q      (mxl_q),
    .sxl_q      (sxl_q),
    .uxl_q      (uxl_q),
    .eff_xl     (eff_xl)
);

// File: tb/xlen_sel_cache_test.sv
module xlen_sel_cache_test;

    localparam int DATA_W = 64;
    localparam int MAX_XL = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        priv_i = 2'd3;
    logic              trap_fire = 1'b0;
    logic [1:0]        trap_priv = 2'd0;
    logic              misa_we = 1'b0;
    logic [DATA_W-1:0] misa_wdata = '0;
    logic              mstatus_we = 1'b0;
    logic [DATA_W-1:0] mstatus_wdata = '0;
    logic [1:0]        eff_xl;
    logic              xl32_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Model state
    int m_mxl, m_sxl, m_uxl, m_code;

    always #2 clk = ~clk;

    xlen_sel_cache #(.DATA_W(DATA_W), .MAX_XL(MAX_XL)) uut (
        .clk           (clk),
        .rst           (rst),
        .priv_i        (priv_i),
        .trap_fire     (trap_fire),
        .trap_priv     (trap_priv),
        .misa_we       (misa_we),
        .misa_wdata    (misa_wdata),
        .mstatus_we    (mstatus_we),
        .mstatus_wdata (mstatus_wdata),
        .eff_xl        (eff_xl),
        .xl32_mode     (xl32_mode)
    );

    function automatic bit legal(input int c);
        return c >= 1 && c <= MAX_XL;
    endfunction

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_mxl = MAX_XL; m_sxl = MAX_XL; m_uxl = MAX_XL; m_code = MAX_XL;
        end else begin
            int nm, ns, nu, p;
            bit lowok;
            nm = m_mxl; ns = m_sxl; nu = m_uxl;
            lowok = (m_mxl != 1);
            if (misa_we && legal(int'(misa_wdata[63:62]))) nm = int'(misa_wdata[63:62]);
            if (mstatus_we && lowok) begin
                if (legal(int'(mstatus_wdata[35:34]))) ns = int'(mstatus_wdata[35:34]);
                if (legal(int'(mstatus_wdata[33:32]))) nu = int'(mstatus_wdata[33:32]);
            end
            p = trap_fire ? int'(trap_priv) : int'(priv_i);
            if (trap_fire || misa_we || mstatus_we) begin
                if (nm == 1)      m_code = 1;
                else if (p == 3)  m_code = nm;
                else if (p == 0)  m_code = nu;
                else              m_code = ns;
            end
            m_mxl = nm; m_sxl = ns; m_uxl = nu;
        end
    end

    // Every-cycle comparison against the model (R6 R11)
    always @(negedge clk) begin
        if (!rst) begin
            total++;
            if (int'(eff_xl) != m_code || xl32_mode != (m_code == 1)) begin
                bad++;
                $display("FAIL R6/R11 model compare: actual code=%0d flag=%0d expected code=%0d flag=%0d",
                         eff_xl, xl32_mode, m_code, (m_code == 1));
            end
        end
    end

    task automatic want(input string req, input int exp);
        total++;
        if (int'(eff_xl) != exp || xl32_mode != (exp == 1)) begin
            bad++;
            $display("FAIL %s: actual code=%0d flag=%0d expected code=%0d flag=%0d",
                     req, eff_xl, xl32_mode, exp, (exp == 1));
        end
    endtask

    // One strobed cycle; returns at the falling edge after the active edge
    task automatic step(input bit tf, input int tp, input bit mw, input int mv,
                        input bit sw, input int sv, input int uv);
        @(negedge clk);
        trap_fire     = tf;
        trap_priv     = 2'(tp);
        misa_we       = mw;
        misa_wdata    = {2'(mv), 62'h0F0F_1234_5678_9ABC};
        mstatus_we    = sw;
        mstatus_wdata = 64'hC3C3_00F0_0000_0F0F;
        mstatus_wdata[35:34] = 2'(sv);
        mstatus_wdata[33:32] = 2'(uv);
        @(negedge clk);
        if (tf) priv_i = 2'(tp);
        trap_fire  = 1'b0;
        misa_we    = 1'b0;
        mstatus_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        want("R1 reset widest", 2);

        step(0, 0, 0, 0, 1, 2, 1);            // M: S=2 U=1
        want("R3 machine uses MXL", 2);

        priv_i = 2'd0;                        // no event
        repeat (3) @(negedge clk);
        want("R6 stale without event", 2);

        step(1, 0, 0, 0, 0, 0, 0);            // trap to U
        want("R7 R4 R11 trap to user", 1);

        step(1, 1, 0, 0, 0, 0, 0);            // trap to S
        want("R5 supervisor uses SXL", 2);

        step(0, 0, 0, 0, 1, 1, 1);            // write in S
        want("R8 status write recompute", 1);

        step(1, 2, 0, 0, 0, 0, 0);            // trap to H
        want("R5 hypervisor uses SXL", 1);

        step(1, 0, 0, 0, 0, 0, 0);            // U
        step(0, 0, 0, 0, 1, 0, 3);            // illegal codes
        want("R9 illegal UXL dropped", 1);
        step(1, 1, 0, 0, 0, 0, 0);
        want("R9 illegal SXL dropped", 1);

        step(1, 3, 0, 0, 0, 0, 0);            // M
        step(0, 0, 0, 0, 1, 2, 2);
        want("R3 machine after status write", 2);

        step(0, 0, 1, 1, 0, 0, 0);            // MXL=32
        want("R2 lock in machine", 1);
        step(1, 0, 0, 0, 0, 0, 0);
        want("R2 lock in user", 1);
        step(1, 1, 0, 0, 0, 0, 0);
        want("R2 lock in supervisor", 1);

        step(0, 0, 0, 0, 1, 1, 1);            // unreachable write
        want("R10 locked status write", 1);
        step(0, 0, 1, 3, 0, 0, 0);            // illegal MXL
        want("R9 illegal MXL keeps lock", 1);
        step(0, 0, 1, 2, 0, 0, 0);            // unlock, in S
        want("R10 SXL kept", 2);
        step(1, 0, 0, 0, 0, 0, 0);
        want("R10 UXL kept", 2);

        step(1, 1, 0, 0, 1, 1, 2);            // trap + write same edge
        want("R7 R8 same-edge trap and write", 1);

        step(1, 3, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);            // MXL=0 illegal
        want("R9 zero MXL dropped", 2);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule